// File: doc/BRIEF.md
# Write Descriptor Beat Sequencer

This block takes a single 160-bit write descriptor and turns it into a series of per-beat transfer commands. Each command gives a local source address, a bus destination address and a byte count. A descriptor is in one of three forms. In incrementing form, both addresses advance by one beat per command. In fixed-source form, the source address stays constant while the destination address advances. In immediate form, the one- or two-dword payload is carried inside the descriptor itself and goes out as a single command.

Before it emits anything, the block checks the descriptor. A descriptor is rejected if its length is zero, if it is immediate with a length other than one or two dwords, if it is fixed-source with a source or destination address that is not 64-byte aligned, or if it is a two-dword immediate write that crosses a 4 KB destination page. A rejected descriptor raises an error pulse with a cause code and produces no beats. The block takes a descriptor only while idle. It reports completion with a done pulse in the cycle the final beat is taken.

Top module: `wdesc_beat_seq`

## Requirements
- R1: During and right after reset, desc_ready_o is 1 and beat_valid_o, done_o and err_o are 0.
- R2: A descriptor is taken on a cycle where desc_valid_i and desc_ready_o are both high. desc_ready_o is high exactly when no beat is pending, so a descriptor offered while beats are pending waits.
- R3: In incrementing mode (bit 147 clear, bit 146 clear), beat k has source address src+64k and destination address dst+64k. The source is bits [63:0] and the destination is bits [127:64].
- R4: In fixed-source mode (bit 147 set, bit 146 clear), every beat carries the unchanged source address, and the destination still advances by 64 per beat.
- R5: A non-immediate descriptor of L dwords (bits [145:128]) gives ceil(L/16) beats. Every beat but the last has a byte count of 64, and the last carries 4L minus 64 times the number of earlier beats.
- R6: An immediate descriptor (bit 146 set) of one or two dwords gives one beat. That beat has beat_imm_o high, a byte count of 4L, a source output of zero, the descriptor destination, and a payload of bits [31:0] zero-extended (L=1) or bits [63:0] (L=2). Bit 147 has no effect in this mode. Non-immediate beats carry a zero payload.
- R7: A descriptor with length zero is rejected with code 1. Rejection means err_o pulses one cycle after acceptance, err_code_o holds the code, and no beat is emitted.
- R8: An immediate descriptor with a length other than 1 or 2 is rejected with code 2.
- R9: A fixed-source, non-immediate descriptor whose source or destination address has any of bits [5:0] set is rejected with code 4.
- R10: A two-dword immediate descriptor whose destination bits [11:0] exceed 0xFF8 is rejected with code 3. A one-dword immediate is never rejected for its page offset. When several causes apply, the priority order is code 1, then 2, then 3, then 4.
- R11: Bits [159:152] and [151:149] appear unchanged on beat_tag_o and beat_app_o for every beat. Bit 148 has no effect on any output.
- R12: While beat_valid_o is high and beat_ready_i is low, every beat output holds its value.
- R13: beat_last_o marks the final beat, and done_o is high exactly in the cycle where that final beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Block idle and able to take a descriptor |
| desc_data_i | input | 160 | Descriptor word |
| beat_valid_o | output | 1 | Beat command valid |
| beat_ready_i | input | 1 | Consumer takes the beat |
| beat_src_o | output | 64 | Local source address of the beat |
| beat_dst_o | output | 64 | Bus destination address of the beat |
| beat_bytes_o | output | 7 | Byte count of the beat |
| beat_imm_o | output | 1 | Beat carries immediate payload |
| beat_data_o | output | 64 | Immediate payload |
| beat_tag_o | output | 8 | Descriptor identifier |
| beat_app_o | output | 3 | Application bits passed through |
| beat_last_o | output | 1 | Final beat of the descriptor |
| done_o | output | 1 | Final beat taken this cycle |
| err_o | output | 1 | Descriptor rejected (one-cycle pulse) |
| err_code_o | output | 3 | Cause of the most recent rejection |

## Verification
Suppose the remaining-length counter holds a wrong value. The byte count of the current beat, or the position of beat_last_o, is then wrong at the first beat that depends on it, and the descriptor either ends early or runs on. An address register that steps wrongly shows up on the next beat's source or destination. A wrong classification shows up one cycle after acceptance, as an err_o pulse where there should be beats or as beats where there should be a pulse. The bench's reference model predicts every output on every cycle, so a fault is seen in the first cycle where it changes a port.

// File: rtl/wdesc_pkg.sv
package wdesc_pkg;

    localparam int DESC_W = 160;
    localparam int LEN_W  = 18;
    localparam int ADDR_W = 64;
    localparam int TAG_W  = 8;
    localparam int APP_W  = 3;

    // Field layout is fixed by the producer of the descriptor word.
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [APP_W-1:0]  app;
        logic              rsvd;
        logic              fixed_src;
        logic              imm;
        logic [LEN_W-1:0]  len_dw;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } wdesc_t;

    typedef enum logic [2:0] {
        WERR_NONE       = 3'd0,
        WERR_ZERO_LEN   = 3'd1,
        WERR_IMM_LEN    = 3'd2,
        WERR_PAGE_CROSS = 3'd3,
        WERR_MISALIGN   = 3'd4
    } werr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    function automatic logic [ADDR_W-1:0] imm_payload(logic [ADDR_W-1:0] raw,
                                                      logic [LEN_W-1:0]  len_dw);
        if (len_dw == LEN_W'(1))
            return {32'd0, raw[31:0]};
        return raw;
    endfunction

endpackage

// File: rtl/wdesc_check.sv
module wdesc_check
    import wdesc_pkg::*;
#(
    parameter int ALIGN_BYTES = 64,
    parameter int PAGE_BYTES  = 4096,
    localparam int AL_W = $clog2(ALIGN_BYTES),
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic [LEN_W-1:0] len_dw_i,
    input  logic             imm_i,
    input  logic             fixed_i,
    input  logic [AL_W-1:0]  src_lo_i,
    input  logic [PG_W-1:0]  dst_lo_i,
    output werr_e            code_o
);
    localparam logic [PG_W-1:0] LAST_SAFE_OFF = PG_W'(PAGE_BYTES - 8);

    logic zero_len, bad_imm_len, crosses_page, misaligned;

    always_comb begin
        zero_len     = (len_dw_i == '0);
        bad_imm_len  = imm_i && (len_dw_i != LEN_W'(1)) && (len_dw_i != LEN_W'(2));
        crosses_page = imm_i && (len_dw_i == LEN_W'(2)) && (dst_lo_i > LAST_SAFE_OFF);
        misaligned   = !imm_i && fixed_i &&
                       ((src_lo_i != '0) || (dst_lo_i[AL_W-1:0] != '0));
    end

    always_comb begin
        if (zero_len)          code_o = WERR_ZERO_LEN;
        else if (bad_imm_len)  code_o = WERR_IMM_LEN;
        else if (crosses_page) code_o = WERR_PAGE_CROSS;
        else if (misaligned)   code_o = WERR_MISALIGN;
        else                   code_o = WERR_NONE;
    end

endmodule

// File: rtl/wdesc_addr_gen.sv
module wdesc_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int STEP   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic              fixed_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic src_fixed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_o       <= '0;
            dst_o       <= '0;
            src_fixed_q <= 1'b0;
        end else if (load_i) begin
            src_o       <= src_i;
            dst_o       <= dst_i;
            src_fixed_q <= fixed_i;
        end else if (step_i) begin
            dst_o <= dst_o + STEP_V;
            if (!src_fixed_q)
                src_o <= src_o + STEP_V;
        end
    end

endmodule

// File: rtl/wdesc_len_track.sv
module wdesc_len_track #(
    parameter int LEN_W   = 18,
    parameter int BEAT_DW = 16,
    localparam int BYTES_W = $clog2(BEAT_DW * 4) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               step_i,
    output logic [BYTES_W-1:0] bytes_o,
    output logic               last_o
);
    localparam logic [LEN_W-1:0] BEAT_V = LEN_W'(BEAT_DW);

    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] chunk;

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (load_i)
            rem_q <= len_i;
        else if (step_i)
            rem_q <= rem_q - BEAT_V;
    end

    always_comb begin
        last_o  = (rem_q <= BEAT_V);
        chunk   = last_o ? rem_q : BEAT_V;
        bytes_o = BYTES_W'({chunk, 2'b00});
    end

endmodule

// File: rtl/wdesc_beat_seq.sv
module wdesc_beat_seq
    import wdesc_pkg::*;
#(
    parameter int BEAT_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    localparam int BEAT_DW = BEAT_BYTES / 4,
    localparam int BYTES_W = $clog2(BEAT_BYTES) + 1,
    localparam int AL_W    = $clog2(BEAT_BYTES),
    localparam int PG_W    = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_valid_i,
    output logic               desc_ready_o,
    input  logic [DESC_W-1:0]  desc_data_i,
    output logic               beat_valid_o,
    input  logic               beat_ready_i,
    output logic [ADDR_W-1:0]  beat_src_o,
    output logic [ADDR_W-1:0]  beat_dst_o,
    output logic [BYTES_W-1:0] beat_bytes_o,
    output logic               beat_imm_o,
    output logic [ADDR_W-1:0]  beat_data_o,
    output logic [TAG_W-1:0]   beat_tag_o,
    output logic [APP_W-1:0]   beat_app_o,
    output logic               beat_last_o,
    output logic               done_o,
    output logic               err_o,
    output logic [2:0]         err_code_o
);
    wdesc_t  d;
    werr_e   cls;
    seq_st_e st_q;
    logic    accept, load, step, taken;
    logic    unused_rsvd;

    assign d           = wdesc_t'(desc_data_i);
    assign unused_rsvd = d.rsvd;

    assign desc_ready_o = (st_q == ST_IDLE);
    assign beat_valid_o = (st_q == ST_RUN);
    assign accept       = desc_valid_i && desc_ready_o;
    assign load         = accept && (cls == WERR_NONE);
    assign taken        = beat_valid_o && beat_ready_i;
    assign step         = taken && !beat_last_o;
    assign done_o       = taken && beat_last_o;

    wdesc_check #(
        .ALIGN_BYTES (BEAT_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_check (
        .len_dw_i (d.len_dw),
        .imm_i    (d.imm),
        .fixed_i  (d.fixed_src),
        .src_lo_i (d.src[AL_W-1:0]),
        .dst_lo_i (d.dst[PG_W-1:0]),
        .code_o   (cls)
    );

    wdesc_addr_gen #(
        .ADDR_W (ADDR_W),
        .STEP   (BEAT_BYTES)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .src_i   (d.imm ? '0 : d.src),
        .dst_i   (d.dst),
        .fixed_i (d.fixed_src),
        .step_i  (step),
        .src_o   (beat_src_o),
        .dst_o   (beat_dst_o)
    );

    wdesc_len_track #(
        .LEN_W   (LEN_W),
        .BEAT_DW (BEAT_DW)
    ) u_len (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .len_i   (d.len_dw),
        .step_i  (step),
        .bytes_o (beat_bytes_o),
        .last_o  (beat_last_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            beat_imm_o  <= 1'b0;
            beat_data_o <= '0;
            beat_tag_o  <= '0;
            beat_app_o  <= '0;
            err_o       <= 1'b0;
            err_code_o  <= 3'd0;
        end else begin
            err_o <= accept && (cls != WERR_NONE);
            if (accept)
                err_code_o <= cls;
            if (load) begin
                st_q        <= ST_RUN;
                beat_imm_o  <= d.imm;
                beat_data_o <= d.imm ? imm_payload(d.src, d.len_dw) : '0;
                beat_tag_o  <= d.tag;
                beat_app_o  <= d.app;
            end else if (done_o) begin
                st_q <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/wdesc_beat_seq_chk.sv
module wdesc_beat_seq_chk #(
    parameter int BEAT_BYTES = 64,
    localparam int BYTES_W = $clog2(BEAT_BYTES) + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               desc_ready_o,
    input logic               beat_valid_o,
    input logic               beat_ready_i,
    input logic [63:0]        beat_src_o,
    input logic [63:0]        beat_dst_o,
    input logic [BYTES_W-1:0] beat_bytes_o,
    input logic               beat_imm_o,
    input logic               beat_last_o,
    input logic               done_o,
    input logic               err_o,
    input logic [2:0]         err_code_o
);
    localparam logic [BYTES_W-1:0] FULL_BEAT = BYTES_W'(BEAT_BYTES);
    localparam logic [63:0]        STEP_V    = 64'(BEAT_BYTES);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_src_o)
            && $stable(beat_dst_o) && $stable(beat_bytes_o) && $stable(beat_last_o));

    // R2
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o |-> !desc_ready_o);

    // R3
    dst_advance_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && beat_ready_i && !beat_last_o |=> beat_dst_o == $past(beat_dst_o) + STEP_V);

    // R5
    bytes_range_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o |-> (beat_bytes_o != '0) && (beat_bytes_o <= FULL_BEAT));

    // R5
    full_beat_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && !beat_last_o |-> beat_bytes_o == FULL_BEAT);

    // R6
    imm_single_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && beat_imm_o |-> beat_last_o && beat_src_o == 64'd0);

    // R7
    err_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !beat_valid_o && err_code_o != 3'd0);

    // R13
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !beat_valid_o);

endmodule

bind wdesc_beat_seq wdesc_beat_seq_chk #(.BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .desc_ready_o (desc_ready_o),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_src_o   (beat_src_o),
    .beat_dst_o   (beat_dst_o),
    .beat_bytes_o (beat_bytes_o),
    .beat_imm_o   (beat_imm_o),
    .beat_last_o  (beat_last_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/test_wdesc_beat_seq.sv
module test_wdesc_beat_seq;
    localparam int CLK_P = 10;
    localparam int BEAT  = 64;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [6:0]  bytes;
        logic        imm;
        logic [63:0] data;
        logic        last;
    } beat_t;

    logic         clk = 0, rst = 1;
    logic         desc_valid_i = 0, beat_ready_i = 0;
    logic [159:0] desc_data_i = '0;
    logic         desc_ready_o, beat_valid_o, beat_imm_o, beat_last_o, done_o, err_o;
    logic [63:0]  beat_src_o, beat_dst_o, beat_data_o;
    logic [6:0]   beat_bytes_o;
    logic [7:0]   beat_tag_o;
    logic [2:0]   beat_app_o, err_code_o;

    int checks = 0, fails = 0;
    int ready_mode = 0, phase = 0;
    beat_t exp_q[$];
    bit          m_err = 0, m_acc = 0;
    logic [2:0]  m_code = 0;
    logic [7:0]  m_tag = 0;
    logic [2:0]  m_app = 0;

    always #(CLK_P/2) clk = ~clk;

    wdesc_beat_seq i_wdesc_beat_seq (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd1: return "R7";
            3'd2: return "R8";
            3'd3: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic model_edge();
        bit busy = exp_q.size() > 0;
        logic [159:0] w = desc_data_i;
        logic [17:0] len = w[145:128];
        logic [63:0] dst = w[127:64], src = w[63:0];
        bit imm = w[146], fixed = w[147];
        m_err = 0;
        m_acc = desc_valid_i && !busy;
        if (busy && beat_ready_i) void'(exp_q.pop_front());
        if (m_acc) begin
            logic [2:0] c;
            if (len == 0) c = 1;
            else if (imm && len != 1 && len != 2) c = 2;
            else if (imm && len == 2 && dst[11:0] > 12'hFF8) c = 3;
            else if (!imm && fixed && (src[5:0] != 0 || dst[5:0] != 0)) c = 4;
            else c = 0;
            m_code = c;
            if (c != 0) m_err = 1;
            else begin
                m_tag = w[159:152];
                m_app = w[151:149];
                if (imm) begin
                    beat_t b;
                    b.src = 0; b.dst = dst; b.bytes = 7'(len * 4); b.imm = 1;
                    b.data = (len == 1) ? {32'd0, src[31:0]} : src; b.last = 1;
                    exp_q.push_back(b);
                end else begin
                    int n = (int'(len) + 15) / 16;
                    for (int k = 0; k < n; k++) begin
                        beat_t b;
                        b.src = fixed ? src : src + 64'(BEAT * k);
                        b.dst = dst + 64'(BEAT * k);
                        b.bytes = (k < n - 1) ? 7'(BEAT) : 7'(int'(len) * 4 - BEAT * (n - 1));
                        b.imm = 0; b.data = 0; b.last = (k == n - 1);
                        exp_q.push_back(b);
                    end
                end
            end
        end
    endtask

    task automatic compare();
        bit busy = exp_q.size() > 0;
        check(desc_ready_o == !busy, "R2 desc_ready_o", 64'(desc_ready_o), 64'(!busy));
        check(beat_valid_o == busy, "R2 beat_valid_o", 64'(beat_valid_o), 64'(busy));
        check(err_o == m_err, "R7 err_o", 64'(err_o), 64'(m_err));
        if (m_err) check(err_code_o == m_code, code_req(m_code), 64'(err_code_o), 64'(m_code));
        if (busy) begin
            beat_t b = exp_q[0];
            check(done_o == (beat_ready_i && b.last), "R13 done_o", 64'(done_o), 64'(beat_ready_i && b.last));
            check(beat_src_o == b.src, "R3/R4 src", beat_src_o, b.src);
            check(beat_dst_o == b.dst, "R3 dst", beat_dst_o, b.dst);
            check(beat_bytes_o == b.bytes, "R5 bytes", 64'(beat_bytes_o), 64'(b.bytes));
            check(beat_imm_o == b.imm, "R6 imm", 64'(beat_imm_o), 64'(b.imm));
            check(beat_data_o == b.data, "R6 data", beat_data_o, b.data);
            check(beat_last_o == b.last, "R13 last", 64'(beat_last_o), 64'(b.last));
            check(beat_tag_o == m_tag, "R11 tag", 64'(beat_tag_o), 64'(m_tag));
            check(beat_app_o == m_app, "R11 app", 64'(beat_app_o), 64'(m_app));
        end else begin
            check(done_o == 0, "R13 done_o idle", 64'(done_o), 64'd0);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        phase++;
        case (ready_mode)
            0: beat_ready_i = 1;
            1: beat_ready_i = phase[0];
            default: beat_ready_i = ($urandom % 3) != 0;
        endcase
    endtask

    task automatic send(input logic [7:0] tag, input logic [2:0] app, input bit rsvd, input bit fixed,
                        input bit imm, input logic [17:0] len, input logic [63:0] dst, input logic [63:0] src);
        desc_data_i  = {tag, app, rsvd, fixed, imm, len, dst, src};
        desc_valid_i = 1;
        do cycle(); while (!m_acc);
        desc_valid_i = 0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) cycle();
        cycle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(desc_ready_o == 1, "R1 ready", 64'(desc_ready_o), 64'd1);
        check(beat_valid_o == 0, "R1 valid", 64'(beat_valid_o), 64'd0);
        check(done_o == 0 && err_o == 0, "R1 done/err", 64'({done_o, err_o}), 64'd0);
        rst = 0;
        cycle();
        // R3 R5 incrementing, 40 dwords -> 64,64,32
        ready_mode = 0;
        send(8'h11, 3'd5, 0, 0, 0, 18'd40, 64'h1000_0000, 64'h2000_0010);
        drain();
        // R12 stalls, R4 fixed-source aligned
        ready_mode = 1;
        send(8'h22, 3'd2, 0, 1, 0, 18'd17, 64'h3000_0040, 64'h4000_0080);
        drain();
        // R5 exact beat and single dword
        send(8'h23, 3'd0, 0, 0, 0, 18'd16, 64'h40, 64'h80);
        drain();
        send(8'h24, 3'd7, 0, 0, 0, 18'd1, 64'h44, 64'h88);
        drain();
        // R6 immediates, R10 edge at 0xFF8 accepted, fixed bit ignored
        ready_mode = 0;
        send(8'h31, 3'd1, 0, 1, 1, 18'd1, 64'h5FFC, 64'hDEAD_BEEF_CAFE_F00D);
        drain();
        send(8'h32, 3'd3, 0, 1, 1, 18'd2, 64'h5FF8, 64'h0123_4567_89AB_CDEF);
        drain();
        // R7 R8 R9 R10 rejections
        send(8'h41, 3'd0, 0, 0, 0, 18'd0, 64'h0, 64'h0);
        drain();
        send(8'h42, 3'd0, 0, 0, 1, 18'd3, 64'h100, 64'h1);
        drain();
        send(8'h43, 3'd0, 0, 0, 1, 18'd0, 64'h100, 64'h1);
        drain();
        send(8'h44, 3'd0, 0, 1, 0, 18'd32, 64'h1000, 64'h2004);
        drain();
        send(8'h45, 3'd0, 0, 1, 0, 18'd32, 64'h1020, 64'h2000);
        drain();
        send(8'h46, 3'd0, 0, 0, 1, 18'd2, 64'h7FFC, 64'h5);
        drain();
        send(8'h47, 3'd0, 0, 1, 1, 18'd3, 64'h7FFC, 64'h5);
        drain();
        // R11 reserved bit has no effect; R2 second descriptor waits while busy
        ready_mode = 2;
        send(8'h51, 3'd6, 1, 0, 0, 18'd33, 64'hA000, 64'hB000);
        send(8'h52, 3'd6, 0, 0, 0, 18'd33, 64'hA000, 64'hB000);
        send(8'h53, 3'd4, 1, 1, 0, 18'd1000, 64'hFFFF_FFFF_FFFF_F000, 64'hC0);
        drain();
        send(8'h54, 3'd1, 0, 0, 0, 18'd5, 64'h3, 64'h7);
        drain();
        finish_run();
    end

endmodule